// File: doc/BRIEF.md
# Byte-Bus Wide Register Access Bridge

This block connects an 8-bit peripheral data bus to two 16-bit registers: a free-running counter word and a compare word. Because the bus is half as wide as the registers, every 16-bit transfer is split into two byte accesses. A single shared byte holding register keeps each transfer coherent. The high byte is always accessed first, and the low byte second.

On a read, fetching the counter's high byte returns that byte and, on the same edge, copies the counter's low byte into the holding register. The following low-byte read returns the copy, so a count step between the two reads cannot tear the word. On a write, the high byte goes only into the holding register. The low-byte write then loads the whole target word in one edge. The holding register is shared by both targets, so interleaving accesses to the two words mixes their bytes. The counter word lives here with a single-step increment input. A word load through the bus wins over that increment.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset the counter word is 0x0000, the compare word is 0xFFFF, the read data is 0x00 and the holding byte is 0x00, so a low-byte counter read returns 0x00.
- R2: A read strobe at address 0 puts the counter's high byte on the read data one edge later and, on that same edge, copies the counter's low byte into the holding byte.
- R3: A read strobe at address 1 returns the holding byte, not the live low byte, even if the counter has changed since the high-byte read.
- R4: A write strobe at address 0 or 2 stores the data byte in the holding byte only; neither the counter word nor the compare word changes.
- R5: A write strobe at address 1 loads the counter word with {holding byte, data byte} one edge later.
- R6: A write strobe at address 3 loads the compare word with {holding byte, data byte} one edge later.
- R7: With the count input high and no counter load, the counter word rises by one per edge and wraps from 0xFFFF to 0x0000.
- R8: A counter load at address 1 and a count step in the same cycle give the loaded word, with no increment.
- R9: One holding byte serves both words: a high byte parked by either address 0 or 2, or copied by a high-byte counter read, is the high half of the next load at address 1 or 3.
- R10: Read strobes at address 2 and 3 return the compare word's high and low bytes directly and leave the holding byte unchanged.
- R11: When read and write strobes are both high, only the write takes place and the read data keeps its value.
- R12: The read data changes only on an edge with a read strobe; in all other cycles it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Byte address: 0 counter high, 1 counter low, 2 compare high, 3 compare low |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | BYTE_W | Write data byte |
| bus_rdata | output | BYTE_W | Registered read data byte |
| count_en | input | 1 | Single-step increment request for the counter word |
| cnt_q | output | 2*BYTE_W | Counter word |
| cmp_q | output | 2*BYTE_W | Compare word |

## Verification
Every result of this block appears one rising edge after the strobe that causes it. Read data, counter and compare words and the holding byte are all registered, and no path adds a second stage. The bench changes the strobes on the falling edge, releases them on the next falling edge, and samples at that same falling edge, half a cycle after the update. Holding-byte contents are observed through low-byte counter reads and through word loads, never through internal signals.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CNT_HI = 2'd0,
    SEL_CNT_LO = 2'd1,
    SEL_CMP_HI = 2'd2,
    SEL_CMP_LO = 2'd3
  } sel_e;

  typedef struct packed {
    logic rd_cnt_hi;
    logic rd_cnt_lo;
    logic rd_cmp_hi;
    logic rd_cmp_lo;
    logic wr_park;
    logic wr_cnt_commit;
    logic wr_cmp_commit;
  } acc_t;

endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
  import wrb_pkg::*;
(
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);

  logic rd_eff;
  sel_e sel;

  // a write strobe masks a simultaneous read strobe
  assign rd_eff = rd & ~wr;
  assign sel    = sel_e'(addr);

  always_comb begin
    acc = '0;
    unique case (sel)
      SEL_CNT_HI: begin
        acc.wr_park   = wr;
        acc.rd_cnt_hi = rd_eff;
      end
      SEL_CNT_LO: begin
        acc.wr_cnt_commit = wr;
        acc.rd_cnt_lo     = rd_eff;
      end
      SEL_CMP_HI: begin
        acc.wr_park   = wr;
        acc.rd_cmp_hi = rd_eff;
      end
      SEL_CMP_LO: begin
        acc.wr_cmp_commit = wr;
        acc.rd_cmp_lo     = rd_eff;
      end
      default: acc = '0;
    endcase
  end

endmodule

// File: rtl/wrb_temp.sv
module wrb_temp #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              park_en,
  input  logic [BYTE_W-1:0] park_data,
  input  logic              cap_en,
  input  logic [BYTE_W-1:0] cap_data,
  output logic [BYTE_W-1:0] temp_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
    end else if (park_en) begin
      temp_q <= park_data;
    end else if (cap_en) begin
      temp_q <= cap_data;
    end
  end

endmodule

// File: rtl/wrb_word_reg.sv
module wrb_word_reg #(
  parameter int                 WORD_W    = 16,
  parameter bit                 HAS_INC   = 1'b0,
  parameter logic [WORD_W-1:0]  RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  input  logic              inc_en,
  output logic [WORD_W-1:0] q
);

  function automatic logic [WORD_W-1:0] step_word(input logic [WORD_W-1:0] w);
    return w + {{(WORD_W-1){1'b0}}, 1'b1};
  endfunction

  logic [WORD_W-1:0] nxt;

  generate
    if (HAS_INC) begin : g_inc
      // a bus load outranks the count step
      always_comb begin
        if (load_en)      nxt = load_word;
        else if (inc_en)  nxt = step_word(q);
        else              nxt = q;
      end
    end else begin : g_plain
      logic unused_inc;
      assign unused_inc = inc_en;
      always_comb begin
        nxt = load_en ? load_word : q;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= nxt;
  end

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int                   BYTE_W    = 8,
  parameter logic [2*BYTE_W-1:0]  CMP_RESET = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [BYTE_W-1:0]    bus_wdata,
  output logic [BYTE_W-1:0]    bus_rdata,
  input  logic                 count_en,
  output logic [2*BYTE_W-1:0]  cnt_q,
  output logic [2*BYTE_W-1:0]  cmp_q
);

  localparam int WORD_W = 2 * BYTE_W;

  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] upper_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] lower_of(input logic [WORD_W-1:0] w);
    return w[BYTE_W-1:0];
  endfunction

  acc_t acc;

  // named events for the checker
  logic              ev_rd_cnt_hi;
  logic              ev_rd_cnt_lo;
  logic              ev_rd_cmp_hi;
  logic              ev_rd_cmp_lo;
  logic              ev_park;
  logic              cnt_load;
  logic              cmp_load;
  logic              rd_any;
  logic [BYTE_W-1:0] temp_q;
  logic [WORD_W-1:0] load_word;
  logic [BYTE_W-1:0] rd_next;

  wrb_decode u_dec (
    .rd   (bus_rd),
    .wr   (bus_wr),
    .addr (bus_addr),
    .acc  (acc)
  );

  assign ev_rd_cnt_hi = acc.rd_cnt_hi;
  assign ev_rd_cnt_lo = acc.rd_cnt_lo;
  assign ev_rd_cmp_hi = acc.rd_cmp_hi;
  assign ev_rd_cmp_lo = acc.rd_cmp_lo;
  assign ev_park      = acc.wr_park;
  assign cnt_load     = acc.wr_cnt_commit;
  assign cmp_load     = acc.wr_cmp_commit;
  assign rd_any       = ev_rd_cnt_hi | ev_rd_cnt_lo | ev_rd_cmp_hi | ev_rd_cmp_lo;

  wrb_temp #(.BYTE_W(BYTE_W)) u_temp (
    .clk       (clk),
    .rst_n     (rst_n),
    .park_en   (ev_park),
    .park_data (bus_wdata),
    .cap_en    (ev_rd_cnt_hi),
    .cap_data  (lower_of(cnt_q)),
    .temp_q    (temp_q)
  );

  assign load_word = join_bytes(temp_q, bus_wdata);

  wrb_word_reg #(
    .WORD_W    (WORD_W),
    .HAS_INC   (1'b1),
    .RESET_VAL ('0)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (cnt_load),
    .load_word (load_word),
    .inc_en    (count_en),
    .q         (cnt_q)
  );

  wrb_word_reg #(
    .WORD_W    (WORD_W),
    .HAS_INC   (1'b0),
    .RESET_VAL (CMP_RESET)
  ) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (cmp_load),
    .load_word (load_word),
    .inc_en    (1'b0),
    .q         (cmp_q)
  );

  always_comb begin
    rd_next = bus_rdata;
    if (ev_rd_cnt_hi)      rd_next = upper_of(cnt_q);
    else if (ev_rd_cnt_lo) rd_next = temp_q;
    else if (ev_rd_cmp_hi) rd_next = upper_of(cmp_q);
    else if (ev_rd_cmp_lo) rd_next = lower_of(cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_any) bus_rdata <= rd_next;
  end

endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [1:0]          bus_addr,
  input logic [BYTE_W-1:0]   bus_wdata,
  input logic [BYTE_W-1:0]   bus_rdata,
  input logic                count_en,
  input logic [2*BYTE_W-1:0] cnt_q,
  input logic [2*BYTE_W-1:0] cmp_q,
  input logic [BYTE_W-1:0]   temp_q
);

  logic wr_hi, wr_cnt_lo, wr_cmp_lo, rd_cnt_hi;
  assign wr_hi     = bus_wr && !bus_addr[0];
  assign wr_cnt_lo = bus_wr && (bus_addr == 2'd1);
  assign wr_cmp_lo = bus_wr && (bus_addr == 2'd3);
  assign rd_cnt_hi = bus_rd && !bus_wr && (bus_addr == 2'd0);

  AST_HI_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_hi |=> (temp_q == $past(cnt_q[BYTE_W-1:0])) && (bus_rdata == $past(cnt_q[2*BYTE_W-1:BYTE_W]))); // R2

  AST_HI_WRITE_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !count_en) |=> ($stable(cnt_q) && $stable(cmp_q) && temp_q == $past(bus_wdata))); // R4

  AST_CNT_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_lo |=> cnt_q == {$past(temp_q), $past(bus_wdata)}); // R5

  AST_CMP_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp_lo |=> cmp_q == {$past(temp_q), $past(bus_wdata)}); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !wr_cnt_lo) |=> cnt_q == $past(cnt_q) + 1'b1); // R7

  AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && wr_cnt_lo) |=> cnt_q == {$past(temp_q), $past(bus_wdata)}); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || bus_wr) |=> $stable(bus_rdata)); // R12

endmodule

bind wide_reg_bridge wrb_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .count_en  (count_en),
  .cnt_q     (cnt_q),
  .cmp_q     (cmp_q),
  .temp_q    (temp_q)
);

// File: tb/sim_wide_reg_bridge.sv
`timescale 1ns/1ps
module sim_wide_reg_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        count_en = 1'b0;
  logic [15:0] cnt_q;
  logic [15:0] cmp_q;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wide_reg_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_en(count_en),
    .cnt_q(cnt_q), .cmp_q(cmp_q)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_byte(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic step_once();
    @(negedge clk);
    count_en = 1'b1;
    @(negedge clk);
    count_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 cnt", cnt_q, 16'h0000);
    check("R1 cmp", cmp_q, 16'hFFFF);
    check("R1 rdata", {8'h00, bus_rdata}, 16'h0000);
    rd_byte(2'd1, d);
    check("R1 holding byte", {8'h00, d}, 16'h0000);
  endtask

  task automatic t_write_words();
    wr_byte(2'd0, 8'h12);
    check("R4 cnt after hi write", cnt_q, 16'h0000);
    wr_byte(2'd1, 8'h34);
    check("R5 cnt load", cnt_q, 16'h1234);
    wr_byte(2'd2, 8'hAB);
    check("R4 cmp after hi write", cmp_q, 16'hFFFF);
    wr_byte(2'd3, 8'hCD);
    check("R6 cmp load", cmp_q, 16'hABCD);
  endtask

  task automatic t_coherent_read();
    logic [7:0] d;
    wr_byte(2'd0, 8'h12);
    wr_byte(2'd1, 8'hFF);
    rd_byte(2'd0, d);
    check("R2 hi read", {8'h00, d}, 16'h0012);
    step_once();
    check("R7 step", cnt_q, 16'h1300);
    rd_byte(2'd1, d);
    check("R3 lo from capture", {8'h00, d}, 16'h00FF);
  endtask

  task automatic t_wrap();
    wr_byte(2'd0, 8'hFF);
    wr_byte(2'd1, 8'hFF);
    step_once();
    check("R7 wrap", cnt_q, 16'h0000);
  endtask

  task automatic t_priority();
    wr_byte(2'd0, 8'h55);
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 8'h66; bus_wr = 1'b1; count_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; count_en = 1'b0;
    check("R8 load wins", cnt_q, 16'h5566);
    @(negedge clk);
    check("R8 no late step", cnt_q, 16'h5566);
  endtask

  task automatic t_shared_temp();
    logic [7:0] d;
    wr_byte(2'd2, 8'h9A);
    wr_byte(2'd1, 8'hBC);
    check("R9 cmp park used by cnt", cnt_q, 16'h9ABC);
    check("R9 cmp untouched", cmp_q, 16'hABCD);
    wr_byte(2'd0, 8'h11);
    rd_byte(2'd0, d);
    check("R2 hi read 9A", {8'h00, d}, 16'h009A);
    wr_byte(2'd3, 8'h22);
    check("R9 capture overwrote park", cmp_q, 16'hBC22);
  endtask

  task automatic t_cmp_read();
    logic [7:0] d;
    rd_byte(2'd2, d);
    check("R10 cmp hi", {8'h00, d}, 16'h00BC);
    rd_byte(2'd3, d);
    check("R10 cmp lo", {8'h00, d}, 16'h0022);
    rd_byte(2'd1, d);
    check("R10 holding unchanged", {8'h00, d}, 16'h00BC);
  endtask

  task automatic t_rd_wr_same();
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h77; bus_rd = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check("R11 rdata held", {8'h00, bus_rdata}, 16'h00BC);
    check("R11 cnt unchanged", cnt_q, 16'h9ABC);
    wr_byte(2'd3, 8'h01);
    check("R11 write took place", cmp_q, 16'h7701);
  endtask

  task automatic t_rdata_hold();
    repeat (3) @(negedge clk);
    check("R12 idle hold", {8'h00, bus_rdata}, 16'h00BC);
    wr_byte(2'd0, 8'h44);
    wr_byte(2'd1, 8'h45);
    check("R12 hold over writes", {8'h00, bus_rdata}, 16'h00BC);
    check("R5 second load", cnt_q, 16'h4445);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_words();
    t_coherent_read();
    t_wrap();
    t_priority();
    t_shared_temp();
    t_cmp_read();
    t_rd_wr_same();
    t_rdata_hold();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule